// File: doc/BRIEF.md
# Segment Playback Sequencer

This block produces the read-address stream for a waveform sample store. The stream is built from a small table of segment entries. Each entry names a first and a last word address, a loop count and a set of marker enables. One word of eight samples is addressed per clock. An optional lead-in group of entries plays once each time playback is started. The block then walks the main group of entries, replaying each one its programmed number of times. The whole main group repeats either a fixed number of times or without end.

Two run modes are supported. In free-running mode a start pulse begins output at once, and the block goes idle after the last programmed pass. In triggered mode a start pulse only arms the block, and each trigger plays the list. Between triggers the block stays on the last word it addressed, with the sample strobe low. An abort input stops everything at once. The sample store is modelled as an internal array with a write port. It returns the data word and per-word marker bits for the current address, and these bits are gated by the entry's enables and given a selectable polarity.

Top module: `seg_sequencer`

## Requirements
- R1: A table entry holds a first word address, a last word address (inclusive, last >= first), a loop field and marker enables. The loop field is the number of plays minus one: 0 means one play and all-ones means 2^20 plays. While playing, `rd_addr` steps by one word per clock from first to last and then restarts at first until the plays are used.
- R2: Entries 0 to `pre_len`-1 form a lead-in that plays once after each start. The main group is entries `pre_len` to `last_idx` (`pre_len` <= `last_idx`).
- R3: With `seq_reps` = N > 0 the main group plays N times. With `seq_reps` = 0 it repeats until abort.
- R4: With `trig_mode` = 0, the first word of entry 0 appears with `smp_valid` high one clock after `start` is sampled. One clock after the final word, `idle` is 1 and `smp_valid` is 0.
- R5: With `trig_mode` = 1, `start` arms the block, which leaves `idle` low and `smp_valid` low. A trigger plays the lead-in and then the main group. At the end the block keeps `rd_addr` and `smp_data` on the last word, with `smp_valid` low. Each later trigger replays only the main group.
- R6: `start` has no effect unless the block is idle.
- R7: `trig` has no effect while words are playing, and has no effect at all in free-running mode.
- R8: `abort` sends the block to idle with `smp_valid` low on the next clock, and it wins over every other input.
- R9: For each marker i, `mark_out[i]` = (stored mark bit i of the word AND the current entry's enable i) XOR `mk_pol[i]` while `smp_valid` is 1. Otherwise `mark_out[i]` = `mk_pol[i]`.
- R10: After reset: `idle` = 1, `smp_valid` = 0, `rd_addr` = 0.
- R11: `smp_data` is the data word last written through the sample write port to address `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse (free-running) or arm pulse (triggered) |
| trig | input | 1 | Trigger pulse for triggered mode |
| abort | input | 1 | Return to idle |
| trig_mode | input | 1 | 0 free-running, 1 triggered |
| pre_len | input | TIW | Number of lead-in entries |
| last_idx | input | TIW | Index of the last main entry |
| seq_reps | input | 8 | Main group passes, 0 endless |
| mk_pol | input | 2 | Marker output polarity |
| tbl_we | input | 1 | Table entry write enable |
| tbl_waddr | input | TIW | Table entry index |
| tbl_wstart | input | 8 | First word address |
| tbl_wstop | input | 8 | Last word address |
| tbl_wloops | input | 20 | Plays minus one |
| tbl_wmken | input | 2 | Marker enables |
| smp_we | input | 1 | Sample store write enable |
| smp_waddr | input | 8 | Sample store word address |
| smp_wdata | input | 16 | Data word |
| smp_wmark | input | 2 | Marker bits for the word |
| rd_addr | output | 8 | Current word address |
| smp_valid | output | 1 | Word is being played |
| smp_data | output | 16 | Data word at `rd_addr` |
| mark_out | output | 2 | Marker outputs |
| idle | output | 1 | Block is idle |

## Verification
The bench sweeps lead-in length, main-group length, pass count and marker polarity. A design that replays the lead-in on every pass, or that stops one pass early or late, gives a word stream of the wrong length or order. An entry with a loop field of zero must play exactly once. If the field is treated as a literal count, that entry would be skipped or looped on without end. In triggered mode the bench checks that the held word stays put and that only the first trigger after arming brings in the lead-in. It also checks that start and trigger pulses sent in the middle of a stream do not disturb it, and that abort during an endless run clears the strobe on the next clock.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int SQ_AW    = 8;   // word address width
    localparam int SQ_DW    = 16;  // modelled data word width
    localparam int SQ_REPW  = 20;  // per-entry loop field width
    localparam int SQ_SREPW = 8;   // main group pass count width
    localparam int SQ_NMK   = 2;   // marker count

    typedef logic [SQ_AW-1:0]   waddr_t;
    typedef logic [SQ_REPW-1:0] loops_t;

    typedef struct packed {
        waddr_t              start;
        waddr_t              stop;
        loops_t              loops;
        logic [SQ_NMK-1:0]   mken;
    } seg_entry_t;

    typedef struct packed {
        logic [SQ_NMK-1:0] mark;
        logic [SQ_DW-1:0]  data;
    } smp_word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_PLAY = 2'd2
    } play_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_ARM,
        ACT_STEP,
        ACT_RELOOP,
        ACT_LOAD,
        ACT_FINISH
    } step_act_t;

    function automatic logic more_passes(logic [SQ_SREPW-1:0] reps,
                                         logic [SQ_SREPW-1:0] left);
        return (reps == '0) || (left > SQ_SREPW'(1));
    endfunction

endpackage

// File: rtl/seqr_seg_table.sv
module seqr_seg_table
    import seqr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [IW-1:0] waddr,
    input  seg_entry_t  wentry,
    input  logic [IW-1:0] cur_idx,
    input  logic [IW-1:0] nxt_idx,
    output seg_entry_t  cur_ent,
    output waddr_t      nxt_start,
    output loops_t      nxt_loops
);

    seg_entry_t ent_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[waddr] <= wentry;
        end
    end

    assign cur_ent   = ent_q[cur_idx];
    assign nxt_start = ent_q[nxt_idx].start;
    assign nxt_loops = ent_q[nxt_idx].loops;

endmodule

// File: rtl/seqr_sample_store.sv
module seqr_sample_store
    import seqr_pkg::*;
#(
    parameter int AW = SQ_AW
) (
    input  logic      clk,
    input  logic      we,
    input  waddr_t    waddr,
    input  smp_word_t wword,
    input  waddr_t    raddr,
    output smp_word_t rword
);

    localparam int WORDS = 1 << AW;

    smp_word_t mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wword;
    end

    assign rword = mem_q[raddr];

endmodule

// File: rtl/seqr_walker.sv
module seqr_walker
    import seqr_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                trig,
    input  logic                abort,
    input  logic                trig_mode,
    input  logic [IW-1:0]       pre_len,
    input  logic [IW-1:0]       last_idx,
    input  logic [SQ_SREPW-1:0] seq_reps,
    input  waddr_t              cur_start,
    input  waddr_t              cur_stop,
    input  waddr_t              nxt_start,
    input  loops_t              nxt_loops,
    output logic [IW-1:0]       cur_idx,
    output logic [IW-1:0]       nxt_idx,
    output waddr_t              rd_addr,
    output play_state_t         state
);

    loops_t               loop_left;
    logic [SQ_SREPW-1:0]  seq_left;
    logic                 played;
    step_act_t            act;
    logic                 wrap;

    assign wrap = (state == ST_PLAY) && (cur_idx == last_idx);

    always_comb begin
        act     = ACT_HOLD;
        nxt_idx = cur_idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (trig_mode) begin
                        act = ACT_ARM;
                    end else begin
                        act     = ACT_LOAD;
                        nxt_idx = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (trig) begin
                    act     = ACT_LOAD;
                    nxt_idx = played ? pre_len : '0;
                end
            end
            ST_PLAY: begin
                if (rd_addr != cur_stop) begin
                    act = ACT_STEP;
                end else if (loop_left != '0) begin
                    act = ACT_RELOOP;
                end else if (cur_idx != last_idx) begin
                    act     = ACT_LOAD;
                    nxt_idx = cur_idx + 1'b1;
                end else if (more_passes(seq_reps, seq_left)) begin
                    act     = ACT_LOAD;
                    nxt_idx = pre_len;
                end else begin
                    act = ACT_FINISH;
                end
            end
            default: act = ACT_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rd_addr   <= '0;
            cur_idx   <= '0;
            loop_left <= '0;
            seq_left  <= '0;
            played    <= 1'b0;
        end else if (abort) begin
            state <= ST_IDLE;
        end else begin
            unique case (act)
                ACT_ARM: begin
                    state  <= ST_WAIT;
                    played <= 1'b0;
                end
                ACT_STEP: begin
                    rd_addr <= rd_addr + 1'b1;
                end
                ACT_RELOOP: begin
                    rd_addr   <= cur_start;
                    loop_left <= loop_left - 1'b1;
                end
                ACT_LOAD: begin
                    rd_addr   <= nxt_start;
                    loop_left <= nxt_loops;
                    cur_idx   <= nxt_idx;
                    state     <= ST_PLAY;
                    if (state != ST_PLAY) begin
                        seq_left <= seq_reps;
                        played   <= 1'b1;
                    end else if (wrap && seq_left != '0) begin
                        seq_left <= seq_left - 1'b1;
                    end
                end
                ACT_FINISH: begin
                    state <= trig_mode ? ST_WAIT : ST_IDLE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/seqr_marker_unit.sv
module seqr_marker_unit
    import seqr_pkg::*;
#(
    parameter int NMK = SQ_NMK
) (
    input  logic           valid,
    input  logic [NMK-1:0] word_mark,
    input  logic [NMK-1:0] ent_en,
    input  logic [NMK-1:0] pol,
    output logic [NMK-1:0] mark_out
);

    for (genvar g = 0; g < NMK; g++) begin : g_mk
        assign mark_out[g] = (valid & word_mark[g] & ent_en[g]) ^ pol[g];
    end

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import seqr_pkg::*;
#(
    parameter int TBL_DEPTH = 8,
    parameter int TIW       = $clog2(TBL_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 trig,
    input  logic                 abort,
    input  logic                 trig_mode,
    input  logic [TIW-1:0]       pre_len,
    input  logic [TIW-1:0]       last_idx,
    input  logic [SQ_SREPW-1:0]  seq_reps,
    input  logic [SQ_NMK-1:0]    mk_pol,
    input  logic                 tbl_we,
    input  logic [TIW-1:0]       tbl_waddr,
    input  logic [SQ_AW-1:0]     tbl_wstart,
    input  logic [SQ_AW-1:0]     tbl_wstop,
    input  logic [SQ_REPW-1:0]   tbl_wloops,
    input  logic [SQ_NMK-1:0]    tbl_wmken,
    input  logic                 smp_we,
    input  logic [SQ_AW-1:0]     smp_waddr,
    input  logic [SQ_DW-1:0]     smp_wdata,
    input  logic [SQ_NMK-1:0]    smp_wmark,
    output logic [SQ_AW-1:0]     rd_addr,
    output logic                 smp_valid,
    output logic [SQ_DW-1:0]     smp_data,
    output logic [SQ_NMK-1:0]    mark_out,
    output logic                 idle
);

    seg_entry_t   wentry;
    seg_entry_t   cur_ent;
    waddr_t       nxt_start;
    loops_t       nxt_loops;
    logic [TIW-1:0] cur_idx;
    logic [TIW-1:0] nxt_idx;
    play_state_t  state;
    smp_word_t    wword;
    smp_word_t    rword;

    assign wentry = '{start: tbl_wstart, stop: tbl_wstop,
                      loops: tbl_wloops, mken: tbl_wmken};
    assign wword  = '{mark: smp_wmark, data: smp_wdata};

    seqr_seg_table #(.DEPTH(TBL_DEPTH), .IW(TIW)) u_table (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .waddr     (tbl_waddr),
        .wentry    (wentry),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx),
        .cur_ent   (cur_ent),
        .nxt_start (nxt_start),
        .nxt_loops (nxt_loops)
    );

    seqr_walker #(.IW(TIW)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .trig      (trig),
        .abort     (abort),
        .trig_mode (trig_mode),
        .pre_len   (pre_len),
        .last_idx  (last_idx),
        .seq_reps  (seq_reps),
        .cur_start (cur_ent.start),
        .cur_stop  (cur_ent.stop),
        .nxt_start (nxt_start),
        .nxt_loops (nxt_loops),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx),
        .rd_addr   (rd_addr),
        .state     (state)
    );

    seqr_sample_store #(.AW(SQ_AW)) u_store (
        .clk   (clk),
        .we    (smp_we),
        .waddr (smp_waddr),
        .wword (wword),
        .raddr (rd_addr),
        .rword (rword)
    );

    assign smp_valid = (state == ST_PLAY);
    assign idle      = (state == ST_IDLE);
    assign smp_data  = rword.data;

    seqr_marker_unit #(.NMK(SQ_NMK)) u_marks (
        .valid     (smp_valid),
        .word_mark (rword.mark),
        .ent_en    (cur_ent.mken),
        .pol       (mk_pol),
        .mark_out  (mark_out)
    );

endmodule

// File: rtl/seqr_chk.sv
module seqr_chk
    import seqr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              trig,
    input logic              abort,
    input logic              idle,
    input logic              smp_valid,
    input logic [SQ_AW-1:0]  rd_addr,
    input logic [SQ_AW-1:0]  cur_start,
    input logic [SQ_NMK-1:0] mark_out,
    input logic [SQ_NMK-1:0] mk_pol,
    input play_state_t       state
);

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (idle && !smp_valid)) else $error("abort did not idle"); // R8

    AST_QUIET_MARKS: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> (mark_out == mk_pol)) else $error("marker level"); // R9

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && $past(smp_valid)) |->
            ((rd_addr == $past(rd_addr) + 1'b1) || (rd_addr == cur_start)))
        else $error("address step"); // R1

    AST_ARMED_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && start && !trig && !abort) |=> (state == ST_WAIT))
        else $error("start disturbed armed block"); // R6

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !trig) |=> $stable(rd_addr))
        else $error("held word moved"); // R5

    AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        idle |-> !smp_valid) else $error("strobe while idle"); // R4

endmodule

bind seg_sequencer seqr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .trig      (trig),
    .abort     (abort),
    .idle      (idle),
    .smp_valid (smp_valid),
    .rd_addr   (rd_addr),
    .cur_start (cur_ent.start),
    .mark_out  (mark_out),
    .mk_pol    (mk_pol),
    .state     (state)
);

// File: tb/tb_seg_sequencer.sv
module tb_seg_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NENT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, trig = 1'b0, abort = 1'b0, trig_mode = 1'b0;
    logic [2:0]  pre_len = '0, last_idx = '0;
    logic [7:0]  seq_reps = '0;
    logic [1:0]  mk_pol = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_waddr = '0;
    logic [7:0]  tbl_wstart = '0, tbl_wstop = '0;
    logic [19:0] tbl_wloops = '0;
    logic [1:0]  tbl_wmken = '0;
    logic        smp_we = 1'b0;
    logic [7:0]  smp_waddr = '0;
    logic [15:0] smp_wdata = '0;
    logic [1:0]  smp_wmark = '0;
    logic [7:0]  rd_addr;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic [1:0]  mark_out;
    logic        idle;

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    int t_st [NENT] = '{10, 20, 30, 40, 50};
    int t_sp [NENT] = '{11, 22, 30, 43, 51};
    int t_lp [NENT] = '{1, 0, 2, 0, 1};
    int t_en [NENT] = '{1, 3, 2, 3, 0};

    int exp_a [2048];
    int exp_e [2048];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_sequencer dut (.*);

    function automatic logic [15:0] mdata(int a);
        return 16'((a * 73 + 11) & 16'hFFFF);
    endfunction

    function automatic logic [1:0] mmark(int a);
        logic [7:0] b;
        b = 8'(a);
        return {b[2], b[0]};
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    endtask

    task automatic add_seg(int e);
        for (int l = 0; l <= t_lp[e]; l++)
            for (int a = t_st[e]; a <= t_sp[e]; a++) begin
                exp_a[exp_n] = a;
                exp_e[exp_n] = t_en[e];
                exp_n++;
            end
    endtask

    task automatic build(bit with_pre, int pre, int last, int passes);
        exp_n = 0;
        if (with_pre)
            for (int e = 0; e < pre; e++) add_seg(e);
        for (int p = 0; p < passes; p++)
            for (int e = pre; e <= last; e++) add_seg(e);
    endtask

    // Compare the expected stream word by word; optionally pulse start or trig mid-stream.
    task automatic check_stream(string req, int poke_i, bit poke_s, bit poke_t);
        for (int i = 0; i < exp_n; i++) begin
            logic [1:0] em;
            em = (mmark(exp_a[i]) & 2'(exp_e[i])) ^ mk_pol;
            chk(smp_valid === 1'b1 && rd_addr === 8'(exp_a[i]), req,
                {23'd0, smp_valid, rd_addr}, {23'd1, 8'(exp_a[i])});
            chk(smp_data === mdata(exp_a[i]), "R11", smp_data, mdata(exp_a[i]));
            chk(mark_out === em, "R9", mark_out, em);
            start = poke_s && (i == poke_i);
            trig  = poke_t && (i == poke_i);
            @(negedge clk);
        end
        start = 1'b0;
        trig  = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(idle === 1'b1 && smp_valid === 1'b0, "R10", {idle, smp_valid}, 2'b10);
        chk(rd_addr === 8'd0 && mark_out === 2'b00, "R10", rd_addr, 0);

        for (int a = 0; a < 256; a++) begin
            smp_we = 1'b1; smp_waddr = 8'(a);
            smp_wdata = mdata(a); smp_wmark = mmark(a);
            @(negedge clk);
        end
        smp_we = 1'b0;
        for (int e = 0; e < NENT; e++) begin
            tbl_we = 1'b1; tbl_waddr = 3'(e);
            tbl_wstart = 8'(t_st[e]); tbl_wstop = 8'(t_sp[e]);
            tbl_wloops = 20'(t_lp[e]); tbl_wmken = 2'(t_en[e]);
            @(negedge clk);
        end
        tbl_we = 1'b0;

        // R7: trigger in free-running idle does nothing
        pulse_trig();
        chk(idle === 1'b1 && smp_valid === 1'b0, "R7", {idle, smp_valid}, 2'b10);

        // R1 R2 R3 R4 R9: sweep over lead-in length, main length, passes, polarity
        for (int pre = 0; pre < 3; pre++)
            for (int k = 0; k < 3; k++)
                for (int ps = 1; ps < 4; ps++) begin
                    pre_len = 3'(pre); last_idx = 3'(pre + k);
                    seq_reps = 8'(ps); mk_pol = 2'((pre + k + ps) % 4);
                    @(negedge clk);
                    build(1, pre, pre + k, ps);
                    pulse_start();
                    check_stream("R2", 3, ps == 2, ps == 3);
                    chk(idle === 1'b1 && smp_valid === 1'b0, "R4", {idle, smp_valid}, 2'b10);
                    chk(mark_out === mk_pol, "R9", mark_out, mk_pol);
                end

        // R3: endless passes, then R8 abort
        pre_len = 3'd1; last_idx = 3'd2; seq_reps = 8'd0; mk_pol = 2'b00;
        @(negedge clk);
        build(1, 1, 2, 4);
        pulse_start();
        check_stream("R3", 5, 1, 0);
        chk(smp_valid === 1'b1 && rd_addr === 8'(t_st[1]), "R3", rd_addr, t_st[1]);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(idle === 1'b1 && smp_valid === 1'b0, "R8", {idle, smp_valid}, 2'b10);

        // R5: triggered mode
        trig_mode = 1'b1; pre_len = 3'd1; last_idx = 3'd3; seq_reps = 8'd2; mk_pol = 2'b01;
        @(negedge clk);
        pulse_start();
        chk(idle === 1'b0 && smp_valid === 1'b0, "R5", {idle, smp_valid}, 2'b00);
        pulse_start();  // R6: start while armed is ignored
        repeat (3) @(negedge clk);
        chk(idle === 1'b0 && smp_valid === 1'b0, "R6", {idle, smp_valid}, 2'b00);
        pulse_trig();
        build(1, 1, 3, 2);
        check_stream("R5", 7, 1, 1);
        chk(smp_valid === 1'b0 && idle === 1'b0, "R5", {idle, smp_valid}, 2'b00);
        repeat (4) @(negedge clk);
        chk(rd_addr === 8'(t_sp[3]) && smp_data === mdata(t_sp[3]), "R5", rd_addr, t_sp[3]);
        chk(mark_out === mk_pol, "R9", mark_out, mk_pol);
        pulse_trig();
        build(0, 1, 3, 2);
        check_stream("R5", 2, 0, 1);
        chk(smp_valid === 1'b0 && rd_addr === 8'(t_sp[3]), "R5", rd_addr, t_sp[3]);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(idle === 1'b1, "R8", idle, 1);
        trig_mode = 1'b0;
        @(negedge clk);
        summary();
    end

endmodule